// File: doc/BRIEF.md
# Memory Test and Checksum Engine

This block walks a contiguous region of one of two on-chip memories on behalf of software. It serves three jobs from the same address and length counters. It can fill the region with a test word. It can read the region back and compare it with that word. It can sum the region as an Internet (TCP/IP) ones'-complement checksum. In the two test jobs the test word is either held constant or rotated one bit left for each successive memory word.

Software drives the block through a small register port. It selects the memory, sets the starting word address, the length in bytes and the test data, and then launches the job. A test job is launched by writing the control register with the diagnostic and enable bits set. A checksum is launched by writing the length with the two top count bits set while diagnostic mode is off. Completion is seen by polling the status register, on the `done` output, or on `irq` when interrupts are enabled. A verify job leaves a sticky error flag and the address of the first bad word. A checksum job leaves the complemented sum in a result register.

Top module: `memtest_cksum_engine`

## Requirements
- R1: After reset every register reads zero except CKSUM, which reads 0xFFFF. `busy`, `done` and `irq` are low, and no memory request is made while the engine is idle.
- R2: A write to CTRL (address 0) that has bit0 (diagnostic) and bit1 (enable) both set starts a test job. A CTRL write with bit0 clear starts nothing and leaves memory untouched.
- R3: With CTRL bit3 (read/write) clear, a test job writes the test word to ceil(N/2) consecutive word addresses. N is COUNT bits [11:0], the first address is BASE (address 1), addresses wrap at the memory size, and the memory is the one selected by CTRL bit2. No other word of either memory changes.
- R4: Byte 0 of a region is bits [15:8] of its first word. For an odd N the last word is accessed with `mem_be`=2'b10: a fill leaves its low byte unchanged, and a verify ignores that byte. Every other access uses `mem_be`=2'b11.
- R5: With CTRL bit4 set, word i of a job uses RIPPLE (address 4) rotated left by i mod 16 bits. With bit4 clear, every word uses PATTERN (address 3).
- R6: With CTRL bit3 set, a test job reads and compares the region. STATUS bit2 becomes a sticky error flag, and FAILADDR (address 8) holds the address of the first mismatching word. Both clear when any job starts.
- R7: A COUNT write with bits [15:14]=2'b11 starts a checksum over its own bits [11:0] bytes when CTRL bit0 is clear. When CTRL bit0 is set, that write starts nothing.
- R8: After a checksum, CKSUM (address 7) holds the complement of the 16-bit ones'-complement, end-around-carry sum of the big-endian words. An odd final byte is padded with a zero low byte. N=0 gives 0xFFFF.
- R9: STATUS bit0 (and `busy`) is high while a job runs. STATUS bit1 (and `done`) sets in the cycle `busy` falls, and writing STATUS with bit1 set clears it.
- R10: `irq` is high whenever `done` is set and IRQEN (address 5) bit0 is set. It stays high until `done` is cleared.
- R11: Writes to CTRL or COUNT while `busy` is high are ignored.
- R12: A job issues at most one word request per cycle, at consecutive addresses. Read data is taken one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_bank | output | 1 | Selects one of the two memories |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | 2 | Byte strobes, bit1 = high byte |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after request |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job completed, held until cleared |
| irq | output | 1 | Completion interrupt |

## Verification
Fills are tried with a constant word and with a rotating word, so that a generator that never advances, or advances in the wrong direction, shows up against the bench's memory snapshot. Verify runs are made on clean regions, on regions with one or more corrupted high bytes, and on odd lengths whose last low byte differs from the expected data. These runs separate a missing compare, a non-sticky flag, a wrong first-fail address and an unmasked tail byte. Checksums run over a known vector, over random data of even, odd and zero length, and over regions that wrap past the top address, which isolates carry folding and odd-byte padding. Launch gating is tried with the wrong mode bit and with writes made during a long job.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  // The checksum defines a 16-bit word; the register bus matches it.
  localparam int WORD_W = 16;
  localparam int REG_W  = 16;
  localparam int RA_W   = 4;
  localparam int CTRL_W = 5;

  // Control bit positions
  localparam int CB_DIAG = 0;
  localparam int CB_EN   = 1;
  localparam int CB_BANK = 2;
  localparam int CB_RW   = 3;
  localparam int CB_RIP  = 4;

  // Status bit positions
  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;
  localparam int SB_ERR  = 2;

  localparam logic [RA_W-1:0] RA_CTRL     = 4'd0;
  localparam logic [RA_W-1:0] RA_BASE     = 4'd1;
  localparam logic [RA_W-1:0] RA_COUNT    = 4'd2;
  localparam logic [RA_W-1:0] RA_PATTERN  = 4'd3;
  localparam logic [RA_W-1:0] RA_RIPPLE   = 4'd4;
  localparam logic [RA_W-1:0] RA_IRQEN    = 4'd5;
  localparam logic [RA_W-1:0] RA_STATUS   = 4'd6;
  localparam logic [RA_W-1:0] RA_CKSUM    = 4'd7;
  localparam logic [RA_W-1:0] RA_FAILADDR = 4'd8;

  typedef enum logic [1:0] {
    OP_FILL   = 2'd0,
    OP_VERIFY = 2'd1,
    OP_CKSUM  = 2'd2
  } op_kind_t;
endpackage

// File: rtl/mtc_regs.sv
module mtc_regs
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              err,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic [WORD_W-1:0] cksum,
  output logic              start,
  output op_kind_t          start_kind,
  output logic              start_ripple,
  output logic [CNT_W-1:0]  start_nbytes,
  output logic [ADDR_W-1:0] base,
  output logic [WORD_W-1:0] pattern,
  output logic [WORD_W-1:0] ripple_base,
  output logic [CTRL_W-1:0] ctrl,
  output logic              done,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] pat_q, rip_q;
  logic              ien_q, done_q, done_d;
  logic wr_ctrl, wr_base, wr_cnt, wr_pat, wr_rip, wr_ien, wr_stat;
  logic go_test, go_cksum;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == RA_CTRL) && !busy;
    wr_cnt  = reg_wr && (reg_addr == RA_COUNT) && !busy;
    wr_base = reg_wr && (reg_addr == RA_BASE);
    wr_pat  = reg_wr && (reg_addr == RA_PATTERN);
    wr_rip  = reg_wr && (reg_addr == RA_RIPPLE);
    wr_ien  = reg_wr && (reg_addr == RA_IRQEN);
    wr_stat = reg_wr && (reg_addr == RA_STATUS);

    go_test  = wr_ctrl && reg_wdata[CB_DIAG] && reg_wdata[CB_EN];
    go_cksum = wr_cnt && (reg_wdata[REG_W-1 -: 2] == 2'b11) && !ctrl_q[CB_DIAG];
    start    = go_test || go_cksum;

    if (go_cksum)            start_kind = OP_CKSUM;
    else if (reg_wdata[CB_RW]) start_kind = OP_VERIFY;
    else                     start_kind = OP_FILL;
    start_ripple = go_test && reg_wdata[CB_RIP];
    start_nbytes = go_cksum ? reg_wdata[CNT_W-1:0] : cnt_q;

    done_d = done_q;
    if (start) done_d = 1'b0;
    else if (wr_stat && reg_wdata[SB_DONE]) done_d = 1'b0;
    if (fin) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      pat_q  <= '0;
      rip_q  <= '0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_base) base_q <= reg_wdata[ADDR_W-1:0];
      if (wr_cnt)  cnt_q  <= reg_wdata[CNT_W-1:0];
      if (wr_pat)  pat_q  <= reg_wdata;
      if (wr_rip)  rip_q  <= reg_wdata;
      if (wr_ien)  ien_q  <= reg_wdata[0];
      done_q <= done_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:     reg_rdata = REG_W'(ctrl_q);
      RA_BASE:     reg_rdata = REG_W'(base_q);
      RA_COUNT:    reg_rdata = REG_W'(cnt_q);
      RA_PATTERN:  reg_rdata = pat_q;
      RA_RIPPLE:   reg_rdata = rip_q;
      RA_IRQEN:    reg_rdata = REG_W'(ien_q);
      RA_STATUS:   reg_rdata = REG_W'({err, done_q, busy});
      RA_CKSUM:    reg_rdata = cksum;
      RA_FAILADDR: reg_rdata = REG_W'(fail_addr);
      default:     reg_rdata = '0;
    endcase
  end

  assign base        = base_q;
  assign pattern     = pat_q;
  assign ripple_base = rip_q;
  assign ctrl        = ctrl_q;
  assign done        = done_q;
  assign irq         = done_q && ien_q;
endmodule

// File: rtl/mtc_patgen.sv
module mtc_patgen
  import mtc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_ripple,
  input  logic [W-1:0] fixed_word,
  input  logic [W-1:0] ripple_seed,
  input  logic         advance,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;
  logic         rip_q, rip_d;
  logic         load_en;

  always_comb begin
    word_d = word_q;
    rip_d  = rip_q;
    if (start) begin
      word_d = start_ripple ? ripple_seed : fixed_word;
      rip_d  = start_ripple;
    end else if (advance && rip_q) begin
      word_d = {word_q[W-2:0], word_q[W-1]};
    end
    load_en = start || advance;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rip_q  <= 1'b0;
    end else if (load_en) begin
      word_q <= word_d;
      rip_q  <= rip_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/mtc_cksum.sv
module mtc_cksum
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, in_word};
    acc_d = acc_q;
    if (start)         acc_d = '0;
    else if (in_valid) acc_d = sum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, sum[WORD_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (start || in_valid) acc_q <= acc_d;
  end

  assign result = ~acc_q;
endmodule

// File: rtl/mtc_seq.sv
module mtc_seq
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_kind_t          start_kind,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [CNT_W-1:0]  start_nbytes,
  input  logic [WORD_W-1:0] pat_word,
  output logic              advance,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              fin,
  output logic              err,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              rv_valid,
  output logic [WORD_W-1:0] rv_word
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;

  st_t               st_q, st_d;
  op_kind_t          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d, nwords;
  logic              odd_q, odd_d;
  logic              pv_q, pv_d;
  logic [ADDR_W-1:0] pa_q;
  logic [WORD_W-1:0] pe_q;
  logic [1:0]        pb_q, cur_be;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic [WORD_W-1:0] mask, rd_m, ex_m;
  logic              issue;

  always_comb begin
    nwords = {1'b0, start_nbytes[CNT_W-1:1]} + {{(CNT_W-1){1'b0}}, start_nbytes[0]};
    issue  = (st_q == S_RUN);
    cur_be = (odd_q && (rem_q == {{(CNT_W-1){1'b0}}, 1'b1})) ? 2'b10 : 2'b11;
    mask   = {{(WORD_W/2){pb_q[1]}}, {(WORD_W/2){pb_q[0]}}};
    rd_m   = mem_rdata & mask;
    ex_m   = pe_q & mask;

    st_d   = st_q;
    kind_d = kind_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    odd_d  = odd_q;
    pv_d   = issue && (kind_q != OP_FILL);
    err_d  = err_q;
    fa_d   = fa_q;

    if (pv_q && (kind_q == OP_VERIFY) && (rd_m != ex_m) && !err_q) begin
      err_d = 1'b1;
      fa_d  = pa_q;
    end

    case (st_q)
      S_IDLE: if (start) begin
        st_d   = (nwords == '0) ? S_DRAIN : S_RUN;
        kind_d = start_kind;
        addr_d = start_base;
        rem_d  = nwords;
        odd_d  = start_nbytes[0];
        pv_d   = 1'b0;
        err_d  = 1'b0;
        fa_d   = '0;
      end
      S_RUN: begin
        addr_d = addr_q + 1'b1;
        rem_d  = rem_q - 1'b1;
        if (rem_q == {{(CNT_W-1){1'b0}}, 1'b1}) st_d = S_DRAIN;
      end
      S_DRAIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= OP_FILL;
      addr_q <= '0;
      rem_q  <= '0;
      odd_q  <= 1'b0;
      pv_q   <= 1'b0;
      err_q  <= 1'b0;
      fa_q   <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      odd_q  <= odd_d;
      pv_q   <= pv_d;
      err_q  <= err_d;
      fa_q   <= fa_d;
    end
  end

  // Read-return pipeline: captured only when a word is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pe_q <= '0;
      pb_q <= 2'b11;
    end else if (issue) begin
      pa_q <= addr_q;
      pe_q <= pat_word;
      pb_q <= cur_be;
    end
  end

  assign advance   = issue;
  assign mem_req   = issue;
  assign mem_we    = issue && (kind_q == OP_FILL);
  assign mem_addr  = addr_q;
  assign mem_be    = cur_be;
  assign mem_wdata = pat_word;
  assign busy      = (st_q != S_IDLE);
  assign fin       = (st_q == S_DRAIN);
  assign err       = err_q;
  assign fail_addr = fa_q;
  assign rv_valid  = pv_q && (kind_q == OP_CKSUM);
  assign rv_word   = rd_m;
endmodule

// File: rtl/memtest_cksum_engine.sv
module memtest_cksum_engine
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              start_w, ripple_w, fin_w, err_w, adv_w, rv_valid_w;
  op_kind_t          kind_w;
  logic [CNT_W-1:0]  nbytes_w;
  logic [ADDR_W-1:0] base_w, fail_w;
  logic [WORD_W-1:0] pat_w, rip_w, word_w, rv_word_w, cksum_w;
  logic [CTRL_W-1:0] ctrl_w;

  // Reset asserts at once and releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  mtc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .fin(fin_w), .err(err_w), .fail_addr(fail_w), .cksum(cksum_w),
    .start(start_w), .start_kind(kind_w), .start_ripple(ripple_w), .start_nbytes(nbytes_w),
    .base(base_w), .pattern(pat_w), .ripple_base(rip_w), .ctrl(ctrl_w),
    .done(done), .irq(irq)
  );

  mtc_patgen #(.W(WORD_W)) u_pat (
    .clk(clk), .rst_n(rst_sn), .start(start_w), .start_ripple(ripple_w),
    .fixed_word(pat_w), .ripple_seed(rip_w), .advance(adv_w), .word(word_w)
  );

  mtc_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .start(start_w), .start_kind(kind_w), .start_base(base_w), .start_nbytes(nbytes_w),
    .pat_word(word_w), .advance(adv_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .fin(fin_w), .err(err_w), .fail_addr(fail_w),
    .rv_valid(rv_valid_w), .rv_word(rv_word_w)
  );

  mtc_cksum u_sum (
    .clk(clk), .rst_n(rst_sn), .start(start_w),
    .in_valid(rv_valid_w), .in_word(rv_word_w), .result(cksum_w)
  );

  assign mem_bank = ctrl_w[CB_BANK];
endmodule

// File: rtl/mtc_sva.sv
module mtc_sva
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              reg_wr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic [CTRL_W-1:0] ctrl,
  input logic              err
);
  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R4: only full or high-byte strobes
  a_r4_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 2'b11 || mem_be == 2'b10));

  // R4: a partial word is the last access of a job
  a_r4_partial_last: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 2'b10) |=> !mem_req);

  // R6: the error flag only drops when a new job starts
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $rose(busy));

  // R9: done rises exactly when the job ends
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R10: interrupt holds until software touches a register
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);

  // R11: control stays fixed through a job
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl));

  // R12: back-to-back requests use consecutive addresses
  a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
endmodule

bind memtest_cksum_engine mtc_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_sn), .busy(busy), .done(done), .irq(irq), .reg_wr(reg_wr),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be), .ctrl(ctrl_w), .err(err_w)
);

// File: tb/memtest_cksum_engine_tb.sv
module memtest_cksum_engine_tb;
  import mtc_pkg::*;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              reg_wr = 1'b0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              mem_req, mem_we, mem_bank, busy, done, irq;
  logic [AW-1:0]     mem_addr;
  logic [1:0]        mem_be;
  logic [15:0]       mem_wdata;
  logic [15:0]       mem_rdata;

  logic [15:0] mem    [2][DEPTH];
  logic [15:0] shadow [2][DEPTH];
  int checks = 0;
  int fails  = 0;

  memtest_cksum_engine #(.ADDR_W(AW), .CNT_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .irq(irq)
  );

  // Memory model: one-cycle read latency, byte strobes on write
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[1]) mem[mem_bank][mem_addr][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_bank][mem_addr][7:0]  <= mem_wdata[7:0];
      end else begin
        mem_rdata <= mem[mem_bank][mem_addr];
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [RA_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [RA_W-1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 5000; k++) begin
      reg_read(RA_STATUS, s);
      if (!s[SB_BUSY]) return;
    end
  endtask

  function automatic logic [15:0] rotl16(input logic [15:0] v, input int n);
    logic [15:0] r = v;
    for (int j = 0; j < (n % 16); j++) r = {r[14:0], r[15]};
    return r;
  endfunction

  function automatic logic [15:0] exp_word(input bit rip, input logic [15:0] pat, input logic [15:0] rb, input int i);
    return rip ? rotl16(rb, i) : pat;
  endfunction

  task automatic model_fill(input int b, input int base, input int n, input bit rip,
                            input logic [15:0] pat, input logic [15:0] rb);
    int nw;
    nw = (n + 1) / 2;
    for (int i = 0; i < nw; i++) begin
      int a;
      logic [15:0] w;
      a = (base + i) % DEPTH;
      w = exp_word(rip, pat, rb, i);
      if (i == nw - 1 && (n % 2) == 1) shadow[b][a][15:8] = w[15:8];
      else shadow[b][a] = w;
    end
  endtask

  function automatic int first_bad(input int b, input int base, input int n, input bit rip,
                                   input logic [15:0] pat, input logic [15:0] rb);
    int nw;
    nw = (n + 1) / 2;
    for (int i = 0; i < nw; i++) begin
      int a;
      logic [15:0] m;
      a = (base + i) % DEPTH;
      m = (i == nw - 1 && (n % 2) == 1) ? 16'hFF00 : 16'hFFFF;
      if ((shadow[b][a] & m) != (exp_word(rip, pat, rb, i) & m)) return a;
    end
    return -1;
  endfunction

  function automatic logic [15:0] cksum_ref(input int b, input int base, input int n);
    int nw;
    logic [16:0] acc;
    nw = (n + 1) / 2;
    acc = '0;
    for (int i = 0; i < nw; i++) begin
      logic [15:0] w;
      w = shadow[b][(base + i) % DEPTH];
      if (i == nw - 1 && (n % 2) == 1) w[7:0] = 8'h00;
      acc = {1'b0, acc[15:0]} + {1'b0, w};
      acc = {1'b0, acc[15:0]} + {16'd0, acc[16]};
    end
    return ~acc[15:0];
  endfunction

  task automatic check_mem(input string req, input string what);
    int fb, fi;
    fb = -1; fi = -1;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++)
        if (fb < 0 && mem[b][i] !== shadow[b][i]) begin fb = b; fi = i; end
    if (fb < 0) check(req, what, 32'd0, 32'd0);
    else check(req, $sformatf("%s bank %0d word %0d", what, fb, fi), {16'd0, mem[fb][fi]}, {16'd0, shadow[fb][fi]});
  endtask

  task automatic poke(input int b, input int a, input logic [15:0] v);
    mem[b][a % DEPTH] = v;
    shadow[b][a % DEPTH] = v;
  endtask

  task automatic rand_region(input int b, input int base, input int nw);
    for (int i = 0; i < nw; i++) poke(b, base + i, 16'($urandom));
  endtask

  task automatic run_test(input int b, input bit rw, input bit rip, input int base, input int n,
                          input logic [15:0] pat, input logic [15:0] rb);
    reg_write(RA_BASE, 16'(base));
    reg_write(RA_COUNT, 16'(n));
    reg_write(RA_PATTERN, pat);
    reg_write(RA_RIPPLE, rb);
    reg_write(RA_CTRL, {11'd0, rip, rw, b[0], 2'b11});
    wait_idle();
  endtask

  task automatic run_cksum(input int b, input int base, input int n);
    reg_write(RA_CTRL, {13'd0, b[0], 2'b00});
    reg_write(RA_BASE, 16'(base));
    reg_write(RA_COUNT, 16'hC000 | 16'(n));
    wait_idle();
  endtask

  task automatic verify_and_check(input string req, input int b, input int base, input int n,
                                  input bit rip, input logic [15:0] pat, input logic [15:0] rb);
    logic [15:0] s, fa;
    int eb;
    eb = first_bad(b, base, n, rip, pat, rb);
    run_test(b, 1'b1, rip, base, n, pat, rb);
    reg_read(RA_STATUS, s);
    check(req, "verify error flag", {31'd0, s[SB_ERR]}, {31'd0, eb >= 0});
    if (eb >= 0) begin
      reg_read(RA_FAILADDR, fa);
      check(req, "first fail address", {16'd0, fa}, 32'(eb));
    end
  endtask

  initial begin
    logic [15:0] r;
    void'($urandom(32'd2024));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) poke(b, i, 16'(i * 3 + b));

    repeat (3) @(negedge clk);
    #1;
    check("R1", "busy during reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(RA_STATUS, r);  check("R1", "status after reset", {16'd0, r}, 32'd0);
    reg_read(RA_CTRL, r);    check("R1", "ctrl after reset", {16'd0, r}, 32'd0);
    reg_read(RA_CKSUM, r);   check("R1", "cksum after reset", {16'd0, r}, 32'h0000FFFF);
    check("R1", "irq and mem_req after reset", {30'd0, irq, mem_req}, 32'd0);

    // R3 fixed fill, R9 completion flags
    model_fill(0, 100, 40, 1'b0, 16'hA5C3, 16'h0);
    run_test(0, 1'b0, 1'b0, 100, 40, 16'hA5C3, 16'h0);
    check_mem("R3", "fixed fill bank0");
    reg_read(RA_STATUS, r);  check("R9", "status after fill", {16'd0, r}, 32'h2);
    check("R9", "done port", {31'd0, done}, 32'd1);
    reg_write(RA_STATUS, 16'h0002);
    reg_read(RA_STATUS, r);  check("R9", "done cleared", {16'd0, r}, 32'd0);

    // R6 clean verify, then corrupted
    verify_and_check("R6", 0, 100, 40, 1'b0, 16'hA5C3, 16'h0);
    poke(0, 110, shadow[0][110] ^ 16'h0100);
    poke(0, 105, shadow[0][105] ^ 16'h8000);
    verify_and_check("R6", 0, 100, 40, 1'b0, 16'hA5C3, 16'h0);
    // R6 flag clears on a new job start
    reg_write(RA_BASE, 16'd600);
    reg_write(RA_COUNT, 16'd2000);
    reg_write(RA_CTRL, 16'h0003);
    reg_read(RA_STATUS, r);
    check("R6", "error cleared at start", {29'd0, r[2:0]}, 32'h1);
    // R11 writes while busy ignored
    reg_write(RA_CTRL, 16'h001F);
    reg_write(RA_COUNT, 16'hC005);
    reg_read(RA_CTRL, r);   check("R11", "ctrl kept while busy", {16'd0, r}, 32'h3);
    reg_read(RA_COUNT, r);  check("R11", "count kept while busy", {16'd0, r}, 32'd2000);
    wait_idle();
    model_fill(0, 600, 2000, 1'b0, 16'hA5C3, 16'h0);
    check_mem("R11", "long fill with original settings");

    // R5 ripple fill wrapping past top of bank1
    model_fill(1, 1000, 50, 1'b1, 16'h0, 16'h8001);
    run_test(1, 1'b0, 1'b1, 1000, 50, 16'h0, 16'h8001);
    check_mem("R5", "ripple fill bank1 with wrap");
    verify_and_check("R5", 1, 1000, 50, 1'b1, 16'h0, 16'h8001);
    poke(1, 3, shadow[1][3] ^ 16'h0400);
    verify_and_check("R5", 1, 1000, 50, 1'b1, 16'h0, 16'h8001);

    // R4 odd length: last low byte untouched and ignored
    for (int i = 0; i < 6; i++) poke(0, 300 + i, 16'h1234);
    model_fill(0, 300, 7, 1'b0, 16'hBEEF, 16'h0);
    run_test(0, 1'b0, 1'b0, 300, 7, 16'hBEEF, 16'h0);
    check_mem("R4", "odd fill keeps tail low byte");
    check("R4", "tail word value", {16'd0, mem[0][303]}, 32'h0000BE34);
    verify_and_check("R4", 0, 300, 7, 1'b0, 16'hBEEF, 16'h0);

    // R2 no launch without diagnostic bit
    reg_write(RA_STATUS, 16'h0002);
    reg_write(RA_BASE, 16'd0);
    reg_write(RA_COUNT, 16'd20);
    reg_write(RA_CTRL, 16'h0002);
    repeat (3) @(negedge clk);
    reg_read(RA_STATUS, r);  check("R2", "no job without diag", {16'd0, r}, 32'd0);
    check_mem("R2", "memory untouched");

    // R7 checksum blocked in diagnostic mode
    reg_write(RA_CTRL, 16'h0001);
    reg_write(RA_COUNT, 16'hC00A);
    repeat (3) @(negedge clk);
    reg_read(RA_STATUS, r);  check("R7", "no checksum in diag mode", {16'd0, r}, 32'd0);

    // R8 known vector
    poke(0, 700, 16'h0001); poke(0, 701, 16'hF203); poke(0, 702, 16'hF4F5); poke(0, 703, 16'hF6F7);
    run_cksum(0, 700, 8);
    reg_read(RA_STATUS, r);  check("R7", "checksum completed", {16'd0, r}, 32'h2);
    reg_read(RA_CKSUM, r);   check("R8", "known vector", {16'd0, r}, 32'h220D);
    poke(0, 710, 16'h1234); poke(0, 711, 16'h5678); poke(0, 712, 16'h9ABC);
    run_cksum(0, 710, 5);
    reg_read(RA_CKSUM, r);   check("R8", "odd length padding", {16'd0, r}, 32'hFD52);
    run_cksum(1, 5, 0);
    reg_read(RA_CKSUM, r);   check("R8", "zero length", {16'd0, r}, 32'hFFFF);
    check_mem("R8", "checksum leaves memory intact");

    // R10 interrupt behaviour
    reg_write(RA_IRQEN, 16'h0001);
    run_cksum(1, 20, 6);
    repeat (3) @(negedge clk);
    check("R10", "irq after done", {31'd0, irq}, 32'd1);
    reg_write(RA_STATUS, 16'h0002);
    #1 check("R10", "irq after clear", {31'd0, irq}, 32'd0);
    reg_write(RA_IRQEN, 16'h0000);
    run_cksum(1, 20, 6);
    #1 check("R10", "irq masked", {30'd0, irq, done}, 32'h1);

    // Random mix
    for (int it = 0; it < 24; it++) begin
      int b, base, n, op;
      bit rip;
      logic [15:0] pat, rb;
      b = $urandom % 2; base = $urandom % DEPTH; n = $urandom % 300; op = $urandom % 2;
      rip = 1'($urandom); pat = 16'($urandom); rb = 16'($urandom);
      rand_region(b, base, (n + 1) / 2);
      if (op == 0) begin
        run_cksum(b, base, n);
        reg_read(RA_CKSUM, r);
        check("R8", $sformatf("random checksum n=%0d", n), {16'd0, r}, {16'd0, cksum_ref(b, base, n)});
      end else begin
        model_fill(b, base, n, rip, pat, rb);
        run_test(b, 1'b0, rip, base, n, pat, rb);
        check_mem(rip ? "R5" : "R3", $sformatf("random fill n=%0d", n));
        if (n > 4) poke(b, base + ($urandom % (n / 2)), shadow[b][(base + 1) % DEPTH] ^ 16'h2000);
        verify_and_check("R6", b, base, n, rip, pat, rb);
      end
    end

    summary();
    $finish;
  end
endmodule